// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block turns one host request for configuration space into the address and cycle type that a PCI host bridge puts on the bus. A request names a bus number, a device/function byte, a register offset, an access size (byte, word or dword), a direction, and write data. The block checks the request, and then either rejects it at once with a status code or issues a single cycle. The issued address carries the configuration address shifted left by five, with a size code in its low bits. Write data is moved onto the byte lanes selected by the offset. The lanes returned by the completion are moved back down and cut to the access width.

Only one request is in flight at a time. The state machine has three states. `S_IDLE` raises `req_ready`. On a handshake it takes the transition *accept-issue* to `S_WAIT`, or the transition *accept-reject* straight to `S_RESP`. `S_WAIT` holds the cycle outputs steady with `cyc_valid` high, and it takes the transition *complete* to `S_RESP` when `cpl_valid` arrives. `S_RESP` shows the response for one cycle and takes the transition *respond* back to `S_IDLE`.

Top module: `cfg_addr_gen`

## Requirements
- R1: `req_ready` is high only in the idle state. A handshake drops it the cycle after. `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` returns in the cycle after that.
- R2: With bus number 0, the configuration address has a single set bit at position 11 plus the device number (`devfn[7:3]`). It carries the function number (`devfn[2:0]`) in bits 10:8 and the register offset unchanged in bits 7:0.
- R3: With bus number 0 and a device number above 12, the request is answered with status 1 (device not found) in the cycle after the handshake, and no cycle is issued.
- R4: With a nonzero bus number, the configuration address is bus in bits 23:16, the whole device/function byte in bits 15:8 and the offset in bits 7:0.
- R5: `cyc_type` is 0 for a bus-0 cycle and 1 for any other bus. It is valid whenever `cyc_valid` is high.
- R6: `cyc_addr` equals the configuration address times 32 plus a size code. The size code is 0x00 for a byte (`req_size` 0), 0x08 for a word (`req_size` 1) and 0x18 for a dword (`req_size` 2).
- R7: Three cases are answered with status 2 (bad register) and issue no cycle: a word request with offset bit 0 set, a dword request with offset bits 1:0 nonzero, and `req_size` 3. This check wins over the check in R3.
- R8: For a write, `cyc_write` is 1 and `cyc_wdata` is the write data cut to the access width (8, 16 or 32 bits) and shifted left by offset[1:0] times 8. For a read, `cyc_write` is 0.
- R9: A read that completes without error returns status 0. Its `rsp_rdata` is `cpl_rdata` shifted right by offset[1:0] times 8 and cut to the access width. A write returns status 0 and zero data.
- R10: A read whose completion has `cpl_err` set returns all ones of the access width, with status 0.
- R11: Any rejected request returns all ones of the access width in `rsp_rdata`. Size code 3 counts as 32 bits wide.
- R12: While `cyc_valid` waits for `cpl_valid`, the address, type, direction and write data do not change. `cyc_valid` falls in the cycle after the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device number [7:3], function number [2:0] |
| req_offset | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-justified |
| cyc_valid | output | 1 | Configuration cycle outstanding |
| cyc_addr | output | 29 | Issued address with size code |
| cyc_type | output | 1 | 0 type-0, 1 type-1 |
| cyc_write | output | 1 | Cycle direction |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cpl_valid | input | 1 | Cycle completion strobe |
| cpl_rdata | input | 32 | Raw read lanes from the bus |
| cpl_err | input | 1 | Cycle ended in error |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 success, 1 device not found, 2 bad register |
| rsp_rdata | output | 32 | Right-justified read data |

## Verification
The bench covers the two limits of the device select: device 12, the highest one that may be issued, and device 13 and 31, which are rejected. A design with an off-by-one limit would issue a cycle with no select bit set, or would refuse a real slot. It sends requests that are both misaligned and aimed at a missing device, so that a design with the checks in the wrong order would report device not found instead of bad register. Word reads at offset 2 and byte writes with dirty upper data bits expose shifts and masks on the wrong lane. Completions that arrive late show whether a design lets the address drift, or drops `cyc_valid`, before the completion comes in.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_NODEV  = 2'd1,
        ST_BADREG = 2'd2
    } cfg_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_RESP
    } fsm_e;

    localparam logic [4:0] CODE_BYTE  = 5'h00;
    localparam logic [4:0] CODE_WORD  = 5'h08;
    localparam logic [4:0] CODE_DWORD = 5'h18;

    function automatic logic [DATA_W-1:0] width_mask(input acc_size_e sz);
        logic [DATA_W-1:0] m;
        unique case (sz)
            SZ_BYTE: m = DATA_W'(32'h0000_00FF);
            SZ_WORD: m = DATA_W'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
#(
    parameter int BUS_W      = 8,
    parameter int DEVFN_W    = 8,
    parameter int OFF_W      = 8,
    parameter int FN_W       = 3,
    parameter int MAX_DEV    = 12,
    parameter int SEL_BASE   = 11,
    parameter int SIZE_SHIFT = 5,
    parameter int CFG_W      = BUS_W + DEVFN_W + OFF_W,
    parameter int ADDR_W     = CFG_W + SIZE_SHIFT
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   offset,
    input  acc_size_e          size,
    output logic [ADDR_W-1:0]  addr,
    output logic               ctype,
    output cfg_status_e        status
);
    localparam int DEV_W = DEVFN_W - FN_W;

    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [CFG_W-1:0] sel;
    logic [CFG_W-1:0] cfg0;
    logic [CFG_W-1:0] cfg1;
    logic [CFG_W-1:0] cfg;
    logic [4:0]       code;
    logic             misaligned;
    logic             dev_missing;

    assign dev = devfn[DEVFN_W-1:FN_W];
    assign fn  = devfn[FN_W-1:0];

    genvar g;
    generate
        for (g = 0; g < CFG_W; g++) begin : g_sel
            if (g >= SEL_BASE && g <= SEL_BASE + MAX_DEV) begin : g_slot
                assign sel[g] = (dev == DEV_W'(g - SEL_BASE));
            end else begin : g_none
                assign sel[g] = 1'b0;
            end
        end
    endgenerate

    assign cfg0  = sel | CFG_W'({fn, offset});
    assign cfg1  = {bus, devfn, offset};
    assign ctype = (bus != '0);
    assign cfg   = ctype ? cfg1 : cfg0;

    always_comb begin
        unique case (size)
            SZ_BYTE:  code = CODE_BYTE;
            SZ_WORD:  code = CODE_WORD;
            SZ_DWORD: code = CODE_DWORD;
            default:  code = CODE_BYTE;
        endcase
    end

    assign addr = {cfg, {SIZE_SHIFT{1'b0}}} | ADDR_W'(code);

    always_comb begin
        unique case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_WORD:  misaligned = offset[0];
            SZ_DWORD: misaligned = (offset[1:0] != 2'b00);
            default:  misaligned = 1'b1;
        endcase
    end

    assign dev_missing = !ctype && (dev > DEV_W'(MAX_DEV));

    always_comb begin
        if (misaligned)       status = ST_BADREG;
        else if (dev_missing) status = ST_NODEV;
        else                  status = ST_OK;
    end

endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
    import cfg_pkg::*;
(
    input  logic [1:0]        w_lane,
    input  acc_size_e         w_size,
    input  logic [DATA_W-1:0] w_data,
    output logic [DATA_W-1:0] w_aligned,
    input  logic [1:0]        r_lane,
    input  acc_size_e         r_size,
    input  logic [DATA_W-1:0] r_raw,
    input  logic              r_err,
    output logic [DATA_W-1:0] r_data
);
    logic [DATA_W-1:0] w_cut;
    logic [DATA_W-1:0] r_shift;
    logic [DATA_W-1:0] r_mask;

    assign w_cut     = w_data & width_mask(w_size);
    assign w_aligned = w_cut << {w_lane, 3'b000};

    assign r_mask  = width_mask(r_size);
    assign r_shift = r_raw >> {r_lane, 3'b000};
    assign r_data  = r_err ? r_mask : (r_shift & r_mask);

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_pkg::*;
#(
    parameter int BUS_W      = 8,
    parameter int DEVFN_W    = 8,
    parameter int OFF_W      = 8,
    parameter int MAX_DEV    = 12,
    parameter int SIZE_SHIFT = 5
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    output logic                                     req_ready,
    input  logic [BUS_W-1:0]                         req_bus,
    input  logic [DEVFN_W-1:0]                       req_devfn,
    input  logic [OFF_W-1:0]                         req_offset,
    input  logic [1:0]                               req_size,
    input  logic                                     req_write,
    input  logic [31:0]                              req_wdata,
    output logic                                     cyc_valid,
    output logic [BUS_W+DEVFN_W+OFF_W+SIZE_SHIFT-1:0] cyc_addr,
    output logic                                     cyc_type,
    output logic                                     cyc_write,
    output logic [31:0]                              cyc_wdata,
    input  logic                                     cpl_valid,
    input  logic [31:0]                              cpl_rdata,
    input  logic                                     cpl_err,
    output logic                                     rsp_valid,
    output logic [1:0]                               rsp_status,
    output logic [31:0]                              rsp_rdata
);
    localparam int CFG_W  = BUS_W + DEVFN_W + OFF_W;
    localparam int ADDR_W = CFG_W + SIZE_SHIFT;

    fsm_e state_q, state_d;

    logic [ADDR_W-1:0] dec_addr;
    logic              dec_type;
    cfg_status_e       dec_status;
    acc_size_e         req_sz;
    logic [DATA_W-1:0] wd_aligned;
    logic [DATA_W-1:0] rd_extract;

    logic [ADDR_W-1:0] addr_q;
    logic              type_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    acc_size_e         size_q;
    logic [1:0]        lane_q;
    cfg_status_e       status_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;

    assign req_sz = acc_size_e'(req_size);

    cfg_decode #(
        .BUS_W      (BUS_W),
        .DEVFN_W    (DEVFN_W),
        .OFF_W      (OFF_W),
        .MAX_DEV    (MAX_DEV),
        .SIZE_SHIFT (SIZE_SHIFT)
    ) u_decode (
        .bus    (req_bus),
        .devfn  (req_devfn),
        .offset (req_offset),
        .size   (req_sz),
        .addr   (dec_addr),
        .ctype  (dec_type),
        .status (dec_status)
    );

    cfg_lane_align u_lane (
        .w_lane    (req_offset[1:0]),
        .w_size    (req_sz),
        .w_data    (req_wdata),
        .w_aligned (wd_aligned),
        .r_lane    (lane_q),
        .r_size    (size_q),
        .r_raw     (cpl_rdata),
        .r_err     (cpl_err),
        .r_data    (rd_extract)
    );

    assign accept = req_valid && req_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        cyc_valid = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    state_d = (dec_status == ST_OK) ? S_WAIT : S_RESP;
                end
            end
            S_WAIT: begin
                cyc_valid = 1'b1;
                if (cpl_valid) state_d = S_RESP;
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // request and response holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            type_q   <= 1'b0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
            size_q   <= SZ_BYTE;
            lane_q   <= 2'b00;
            status_q <= ST_OK;
            rdata_q  <= '0;
        end else begin
            if (accept) begin
                addr_q   <= dec_addr;
                type_q   <= dec_type;
                write_q  <= req_write;
                wdata_q  <= req_write ? wd_aligned : '0;
                size_q   <= req_sz;
                lane_q   <= req_offset[1:0];
                status_q <= dec_status;
                rdata_q  <= width_mask(req_sz);
            end else if (state_q == S_WAIT && cpl_valid) begin
                rdata_q  <= write_q ? '0 : rd_extract;
            end
        end
    end

    assign cyc_addr   = addr_q;
    assign cyc_type   = type_q;
    assign cyc_write  = write_q;
    assign cyc_wdata  = wdata_q;
    assign rsp_status = status_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk #(
    parameter int ADDR_W = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cyc_valid,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              cyc_type,
    input logic              cyc_write,
    input logic [31:0]       cyc_wdata,
    input logic              cpl_valid,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status
);
    // R1
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R1
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // R1
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, cyc_valid, rsp_valid}));

    // R2
    type0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && !cyc_type |-> $countones(cyc_addr[ADDR_W-1:16]) == 1);

    // R6
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_addr[4:0] == 5'h00 || cyc_addr[4:0] == 5'h08 ||
                       cyc_addr[4:0] == 5'h18));

    // R3 R7
    reject_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status != 2'd0 |-> $past(req_ready));

    // R12
    hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && !cpl_valid |=> cyc_valid && $stable(cyc_addr) &&
            $stable(cyc_type) && $stable(cyc_write) && $stable(cyc_wdata));

    // R12
    cpl_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cpl_valid |=> !cyc_valid && rsp_valid);

endmodule

bind cfg_addr_gen cfg_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cfg_addr_gen_tb.sv
module cfg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [7:0]  req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        cyc_valid;
    logic [28:0] cyc_addr;
    logic        cyc_type;
    logic        cyc_write;
    logic [31:0] cyc_wdata;
    logic        cpl_valid = 1'b0;
    logic [31:0] cpl_rdata = '0;
    logic        cpl_err = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg_addr_gen u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic longint ones_of(input int sz);
        if (sz == 0) return 64'hFF;
        if (sz == 1) return 64'hFFFF;
        return 64'hFFFF_FFFF;
    endfunction

    function automatic int exp_status(input int bus, input int devfn, input int off, input int sz);
        if (sz == 3 || (sz == 1 && off % 2 != 0) || (sz == 2 && off % 4 != 0)) return 2;
        if (bus == 0 && (devfn / 8) > 12) return 1;
        return 0;
    endfunction

    function automatic longint exp_addr(input int bus, input int devfn, input int off, input int sz);
        longint cfg;
        longint code;
        if (bus == 0) cfg = (longint'(1) << (11 + devfn / 8)) + (devfn % 8) * 256 + off;
        else          cfg = bus * 65536 + devfn * 256 + off;
        code = (sz == 0) ? 0 : (sz == 1) ? 8 : 24;
        return cfg * 32 + code;
    endfunction

    task automatic run(input int bus, input int devfn, input int off, input int sz,
                       input bit wr, input longint wd, input int delay,
                       input longint raw, input bit err);
        int     st;
        longint m;
        longint exp_wd;
        longint exp_rd;
        st = exp_status(bus, devfn, off, sz);
        m  = ones_of(sz);
        exp_wd = wr ? (((wd & m) << ((off % 4) * 8)) & 64'hFFFF_FFFF) : 0;
        if (wr)       exp_rd = 0;
        else if (err) exp_rd = m;
        else          exp_rd = (raw >> ((off % 4) * 8)) & m;

        @(negedge clk);
        chk("R1 ready idle", req_ready, 1);
        req_bus = 8'(bus); req_devfn = 8'(devfn); req_offset = 8'(off);
        req_size = 2'(sz); req_write = wr; req_wdata = 32'(wd);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 ready dropped", req_ready, 0);
        if (st != 0) begin
            chk("R3 R7 no cycle on reject", cyc_valid, 0);
            chk("R1 rsp strobe", rsp_valid, 1);
            chk("R3 R7 status", rsp_status, st);
            chk("R11 reject data", rsp_rdata, m);
        end else begin
            for (int d = 0; d <= delay; d++) begin
                chk("R12 cycle held", cyc_valid, 1);
                chk("R2 R4 R6 address", cyc_addr, exp_addr(bus, devfn, off, sz));
                chk("R5 type", cyc_type, (bus != 0) ? 1 : 0);
                chk("R8 direction", cyc_write, wr);
                if (wr) chk("R8 write lanes", cyc_wdata, exp_wd);
                chk("R1 no early rsp", rsp_valid, 0);
                if (d == delay) begin
                    cpl_valid = 1'b1; cpl_rdata = 32'(raw); cpl_err = err;
                end
                @(negedge clk);
            end
            cpl_valid = 1'b0; cpl_err = 1'b0;
            chk("R12 cycle released", cyc_valid, 0);
            chk("R1 rsp strobe", rsp_valid, 1);
            chk("R9 R10 status ok", rsp_status, 0);
            chk("R9 R10 read data", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk("R1 rsp one cycle", rsp_valid, 0);
        chk("R1 ready back", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset no cycle", cyc_valid, 0);
        chk("R1 reset no rsp", rsp_valid, 0);
        rst_n = 1'b1;

        // R2 R6 type-0 dword read, device 0
        run(0, 8'h00, 8'h00, 2, 0, 0, 0, 64'h1122_3344, 0);
        // R2 highest legal device, byte read at lane 2
        run(0, 12*8+5, 8'h3E, 0, 0, 0, 2, 64'hAABB_CCDD, 0);
        // R3 device 13 and 31
        run(0, 13*8, 8'h00, 2, 0, 0, 0, 0, 0);
        run(0, 31*8+7, 8'h01, 0, 1, 64'h55, 0, 0, 0);
        // R4 R8 type-1 word write at lane 2
        run(3, 8'hA9, 8'h42, 1, 1, 64'h1234, 1, 0, 0);
        // R4 R8 type-1 byte write, dirty upper bits
        run(255, 8'hFF, 8'hFD, 0, 1, 64'hFFFF_FF5A, 0, 0, 0);
        // R7 misaligned word, dword, size 3, and priority over R3
        run(1, 8'h08, 8'h41, 1, 0, 0, 0, 0, 0);
        run(1, 8'h08, 8'h42, 2, 0, 0, 0, 0, 0);
        run(1, 8'h08, 8'h40, 3, 0, 0, 0, 0, 0);
        run(0, 20*8, 8'h03, 1, 0, 0, 0, 0, 0);
        // R10 error completions
        run(0, 8'h10, 8'h05, 0, 0, 0, 0, 64'h1234_5678, 1);
        run(2, 8'h10, 8'h08, 2, 0, 0, 3, 64'h1234_5678, 1);
        // R9 word read upper half; dword write with long wait (R12)
        run(0, 8'h19, 8'h06, 1, 0, 0, 0, 64'hDEAD_BEEF, 0);
        run(9, 8'h01, 8'hFC, 2, 1, 64'hCAFE_F00D, 5, 0, 0);
        // R9 write with error completion still returns zero data
        run(4, 8'h02, 8'h10, 2, 1, 64'h0BAD_0BAD, 0, 64'hFFFF_FFFF, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule